// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Bank

This block is a bank of general-purpose pins placed behind a small 32-bit register bus. Each pin is either an input or an output, chosen by a direction register. Output pins are driven from a data register. Every pad input passes through a two-stage synchronizer before any logic uses it. That synchronized value can be read back, compared against a per-pin level polarity, and checked for edges.

Each pin has two interrupt sources that work side by side. The first is a level source: it follows the synchronized pin through a polarity inversion and a mask. The second is an edge source: a rising or falling transition, picked per pin, sets a sticky event bit, and software clears that bit by writing a one to it. An event mask decides whether a latched event counts as an interrupt. All per-pin sources are combined into one pending flag. A one-bit enable then gates that flag onto a single registered interrupt request line.

Software programs the direction and data registers to drive pins, and reads the data-in register to sample them. For interrupts, it picks a polarity, enables the source in its mask, sets the top-level enable, and on a request reads the event register and the data-in register to find the cause.

Top module: `gpio_irq_bank`

## Requirements
- R1: After a synchronous reset, every register reads zero. `pad_oe` and `pad_out` are all zero, and `irq_out` is low.
- R2: A write to offset 0x48 sets the direction bits, where a bit of 1 makes the pin an output. A write to offset 0x44 sets the output data. Both appear on `pad_oe` and `pad_out` one cycle after the write and read back unchanged.
- R3: Offset 0x40 returns the pad inputs after two synchronizer flops. A pad change shows up in a read issued two or more cycles later, and does not show up in a read issued one cycle later. Writes to 0x40 have no effect.
- R4: Per pin, the level source is (data_in XOR level_polarity) AND level_mask. Level polarity is at 0x50 and level mask at 0x54. A polarity bit of 1 makes a pin request while it is low.
- R5: Edge polarity at 0x64 picks the edge per pin: 0 selects rising and 1 selects falling. A detected edge sets that pin's bit in the event register at 0x58.
- R6: Writing 1 to an event bit clears it, and writing 0 leaves it as it is. No event bit ever clears without such a write.
- R7: If an edge is detected in the same cycle that software writes 1 to clear that event bit, the bit stays set.
- R8: Event bits latch edges whatever the event mask at 0x5C holds. The mask only decides whether a latched event counts as an interrupt.
- R9: Bit 0 of offset 0x00 reads 1 when any level or masked edge source is active. `irq_out` goes high one cycle after that flag is set, but only while bit 0 of the enable register at 0x04 is 1.
- R10: Register bits at and above `N_PINS` read as zero, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe; data returns on the next cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | N_PINS | Asynchronous pad inputs |
| pad_oe | output | N_PINS | Per-pin output enable |
| pad_out | output | N_PINS | Per-pin output data |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
An edge that is being detected and a software write-one-to-clear of the same event bit can land on the same clock edge. The bench provokes this by raising a pad, waiting for the pad value to pass through the synchronizer, and timing the clear write so that it lands on the same cycle as the detection. The event register is then read back. The bit is expected to stay set, and a plain clear afterwards is expected to empty it.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_TOP_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_TOP_EN   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIN      = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_DOUT     = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_OE       = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_LVL_POL  = 8'h50;
  localparam logic [ADDR_W-1:0] OFS_LVL_MSK  = 8'h54;
  localparam logic [ADDR_W-1:0] OFS_EVT      = 8'h58;
  localparam logic [ADDR_W-1:0] OFS_EVT_MSK  = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_EDG_POL  = 8'h64;
endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int WIDTH = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] fall_sel,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] event_q
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] hit;

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      hit[i] = fall_sel[i] ? (prev_q[i] & ~level[i]) : (level[i] & ~prev_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      event_q <= '0;
    end else begin
      prev_q  <= level;
      event_q <= (event_q & ~clr_vec) | hit;
    end
  end
endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] lvl_pol,
  input  logic [WIDTH-1:0] lvl_msk,
  input  logic [WIDTH-1:0] event_q,
  input  logic [WIDTH-1:0] evt_msk,
  input  logic             top_en,
  output logic             any_pend,
  output logic             irq_q
);
  logic [WIDTH-1:0] lvl_src;
  logic [WIDTH-1:0] edg_src;

  assign lvl_src  = (level ^ lvl_pol) & lvl_msk;
  assign edg_src  = event_q & evt_msk;
  assign any_pend = |(lvl_src | edg_src);

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_pend & top_en;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_out,
  output logic              irq_out
);
  localparam int SYNC_STAGES = 2;

  logic [N_PINS-1:0] dout_q, oe_q, lpol_q, lmsk_q, epol_q, emsk_q;
  logic [N_PINS-1:0] din, evt_q, clr_vec, wr_bits;
  logic              top_en_q, any_pend;
  logic [DATA_W-1:0] rd_mux;

  assign wr_bits = bus_wdata[N_PINS-1:0];

  gpio_sync_bank #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(din)
  );

  assign clr_vec = (bus_wr_en && bus_addr == OFS_EVT) ? wr_bits : '0;

  gpio_edge_latch #(.WIDTH(N_PINS)) u_edge (
    .clk(clk), .rst(rst), .level(din), .fall_sel(epol_q),
    .clr_vec(clr_vec), .event_q(evt_q)
  );

  gpio_irq_merge #(.WIDTH(N_PINS)) u_merge (
    .clk(clk), .rst(rst), .level(din), .lvl_pol(lpol_q), .lvl_msk(lmsk_q),
    .event_q(evt_q), .evt_msk(emsk_q), .top_en(top_en_q),
    .any_pend(any_pend), .irq_q(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q   <= '0;
      oe_q     <= '0;
      lpol_q   <= '0;
      lmsk_q   <= '0;
      epol_q   <= '0;
      emsk_q   <= '0;
      top_en_q <= 1'b0;
    end else if (bus_wr_en) begin
      case (bus_addr)
        OFS_TOP_EN:  top_en_q <= bus_wdata[0];
        OFS_DOUT:    dout_q   <= wr_bits;
        OFS_OE:      oe_q     <= wr_bits;
        OFS_LVL_POL: lpol_q   <= wr_bits;
        OFS_LVL_MSK: lmsk_q   <= wr_bits;
        OFS_EVT_MSK: emsk_q   <= wr_bits;
        OFS_EDG_POL: epol_q   <= wr_bits;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_TOP_STAT: rd_mux[0] = any_pend;
      OFS_TOP_EN:   rd_mux[0] = top_en_q;
      OFS_DIN:      rd_mux[N_PINS-1:0] = din;
      OFS_DOUT:     rd_mux[N_PINS-1:0] = dout_q;
      OFS_OE:       rd_mux[N_PINS-1:0] = oe_q;
      OFS_LVL_POL:  rd_mux[N_PINS-1:0] = lpol_q;
      OFS_LVL_MSK:  rd_mux[N_PINS-1:0] = lmsk_q;
      OFS_EVT:      rd_mux[N_PINS-1:0] = evt_q;
      OFS_EVT_MSK:  rd_mux[N_PINS-1:0] = emsk_q;
      OFS_EDG_POL:  rd_mux[N_PINS-1:0] = epol_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
    else                bus_rdata <= '0;
  end

  assign pad_oe  = oe_q;
  assign pad_out = dout_q;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_PINS-1:0] pad_oe,
  input logic              irq_out,
  input logic              top_en,
  input logic [N_PINS-1:0] evt
);
  localparam logic [DATA_W-1:0] LIVE = (N_PINS >= DATA_W) ? '1 : ((DATA_W'(1) << N_PINS) - 1);

  AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr_en) && $past(bus_addr) == OFS_OE) |-> pad_oe == $past(bus_wdata[N_PINS-1:0])); // R2

  AST_EVT_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !($past(bus_wr_en) && $past(bus_addr) == OFS_EVT) |-> ((evt & $past(evt)) == $past(evt))); // R6

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(top_en) |-> !irq_out); // R9

  AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rdata & ~LIVE) == '0); // R10
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
  .irq_out(irq_out), .top_en(top_en_q), .evt(evt_q)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr_en = 1'b0;
  logic          bus_rd_en = 1'b0;
  logic [7:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_oe, pad_out;
  logic          irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit ended = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  logic  rd_seen = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.N_PINS(N)) uut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .irq_out(irq_out)
  );

  always @(posedge clk) rd_seen <= bus_rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_cmp++;
      if (bus_rdata !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 irq_out", 32'(irq_out), 0);
    rd(8'h48, 0, "R1 oe reg");
    rd(8'h54, 0, "R1 level mask");
    rd(8'h04, 0, "R1 top enable");

    // R2 direction and data
    wr(8'h48, 32'h0000_00F0);
    chk("R2 pad_oe", 32'(pad_oe), 32'h00F0);
    wr(8'h44, 32'h0000_A5A5);
    chk("R2 pad_out", 32'(pad_out), 32'hA5A5);
    rd(8'h44, 32'h0000_A5A5, "R2 dout readback");

    // R10 bits above N_PINS
    wr(8'h44, 32'hFFFF_FFFF);
    rd(8'h44, 32'h0000_FFFF, "R10 upper dout bits");

    // R3 two-flop synchronizer, read-only data in
    @(negedge clk);
    pad_in = 16'h1234;
    rd(8'h40, 32'h0, "R3 one cycle late");
    rd(8'h40, 32'h1234, "R3 after sync");
    wr(8'h40, 32'h0000_FFFF);
    rd(8'h40, 32'h1234, "R3 write ignored");

    // R8 events latched with mask off, R5 rising edges
    wr(8'h04, 32'h1);
    rd(8'h58, 32'h1234, "R5 R8 rising events latched");
    chk("R8 irq with event mask off", 32'(irq_out), 0);
    // R6 clear only where ones are written
    wr(8'h58, 32'h0000_0004);
    rd(8'h58, 32'h1230, "R6 partial clear");
    wr(8'h58, 32'h0000_FFFF);
    rd(8'h58, 32'h0, "R6 full clear");

    // R4 level source, R9 aggregation
    wr(8'h54, 32'h0000_0001);
    idle(2);
    chk("R4 high-active idle", 32'(irq_out), 0);
    rd(8'h00, 32'h0, "R4 status idle");
    wr(8'h50, 32'h0000_0001);
    idle(2);
    chk("R4 low-active request", 32'(irq_out), 1);
    rd(8'h00, 32'h1, "R9 status set");
    wr(8'h04, 32'h0);
    idle(2);
    chk("R9 enable off", 32'(irq_out), 0);
    rd(8'h00, 32'h1, "R9 status still set");
    wr(8'h54, 32'h0);
    wr(8'h04, 32'h1);

    // R5 falling edge select
    wr(8'h64, 32'h0000_0004);
    @(negedge clk);
    pad_in = 16'h1230;
    idle(4);
    rd(8'h58, 32'h0004, "R5 falling event");
    wr(8'h5C, 32'h0000_0004);
    idle(2);
    chk("R8 masked event raises irq", 32'(irq_out), 1);
    wr(8'h58, 32'h0000_0004);
    idle(2);
    chk("R6 clear drops irq", 32'(irq_out), 0);

    // R7 edge wins over same-cycle clear
    @(negedge clk);
    pad_in = 16'h1238;
    idle(4);
    @(negedge clk);
    pad_in = 16'h1230;
    idle(4);
    wr(8'h58, 32'h0000_FFFF);
    rd(8'h58, 32'h0, "R7 setup clear");
    @(negedge clk);
    pad_in = 16'h1238;
    @(negedge clk);
    wr(8'h58, 32'h0000_0008);
    rd(8'h58, 32'h0008, "R7 edge beats clear");
    wr(8'h58, 32'h0000_0008);
    rd(8'h58, 32'h0, "R7 later clear");

    idle(3);
    finish_run();
  end
endmodule